// File: doc/BRIEF.md
# Broadcast Write Snoop Receiver

This block sits on a node of a loosely coupled multiprocessor. It watches every cycle on the shared global bus and takes in those broadcast writes that local software has chosen to replicate. A cycle is a broadcast when its address modifier falls in the user-defined range 0x10 to 0x1F. The receiver keeps its own page table, indexed by the top bits of the global address. Each entry holds an accept flag and a local page number. An accepted write lands in local memory at the remapped page, with the in-page offset kept.

Address and data are captured on the first clock that sees the address strobe high. This happens before the sending master's own acknowledge can end the cycle; the receiver never acknowledges. The captured write waits in a single holding slot. It is offered to local memory over a request/grant pair, so a busy memory can finish the write later. An accepted broadcast that finds the slot occupied is lost, and a sticky overrun flag records the loss.

Top module: `bcast_snoop_rx`

## Requirements
- R1: After reset, lw_req and overrun are low and every page table entry has its accept flag clear, so no broadcast is taken in until software sets a flag.
- R2: Only a cycle whose gb_am value lies in 0x10..0x1F (gb_am[5:4] == 2'b01) can be accepted; any other modifier value, including 0x0F and 0x20, is ignored.
- R3: A cycle with gb_write low (a read) is never accepted, whatever its modifier and page.
- R4: The page table index is gb_addr[15:12]. A broadcast write to a page whose accept flag is clear is ignored.
- R5: An accepted write is presented with lw_addr = {local page of the entry, gb_addr[11:0]} and lw_data equal to gb_data. Both are sampled on the capture clock.
- R6: Capture happens only on the clock edge where gb_strobe is first seen high. A strobe held high for several clocks yields exactly one local write.
- R7: lw_req rises on the clock after capture. It stays high with lw_addr and lw_data unchanged until lw_gnt is sampled high, and falls on the following clock unless a new write is captured on that edge.
- R8: An accepted broadcast that arrives while the holding slot is full and not being granted is dropped. overrun is then set and stays set until reset, and the pending write is unchanged.
- R9: An accepted broadcast whose capture edge is the same edge on which the pending write is granted is taken in without setting overrun.
- R10: Pulsing cfg_we for one clock writes cfg_accept and cfg_lpage into entry cfg_idx. Later broadcasts use the new contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gb_strobe | input | 1 | Global bus address strobe, high during a cycle |
| gb_write | input | 1 | Global bus direction, 1 = write |
| gb_am | input | 6 | Global bus address modifier |
| gb_addr | input | 16 | Global bus address |
| gb_data | input | 16 | Global bus write data |
| cfg_we | input | 1 | Page table write enable |
| cfg_idx | input | 4 | Page table entry to write |
| cfg_accept | input | 1 | Accept flag to store |
| cfg_lpage | input | 4 | Local page number to store |
| lw_req | output | 1 | Local write request |
| lw_addr | output | 16 | Local physical write address |
| lw_data | output | 16 | Local write data |
| lw_gnt | input | 1 | Local memory grant |
| overrun | output | 1 | Sticky flag: a broadcast was lost |

## Verification
On every cycle, the bound checker covers the handshake and the overrun flag. A waiting request must keep its address and data. A granted request must drop unless a new capture coincides. overrun never clears, and it can only rise while a request is pending and ungranted. A new request must trace back to a strobed write with a user-range modifier. The remaining properties need the bench's scenarios. These are: the page filter and the remapped address for chosen table contents, the modifier boundaries 0x0F/0x10/0x1F/0x20, a single write from a long strobe, the slot freed and refilled on the same edge, and rewriting a table entry.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int AM_W = 6;
  // user-defined modifier window: upper two bits of the 6-bit code equal 01
  localparam logic [1:0] AM_USER_TOP = 2'b01;

  typedef enum logic {
    SLOT_EMPTY = 1'b0,
    SLOT_FULL  = 1'b1
  } slot_state_e;
endpackage

// File: rtl/bsr_map_table.sv
module bsr_map_table #(
  parameter int IDX_W = 4,
  parameter int LPG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_accept,
  input  logic [LPG_W-1:0] wr_lpage,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_accept,
  output logic [LPG_W-1:0] rd_lpage
);
  localparam int ENTRIES = 1 << IDX_W;

  logic             acc_arr [ENTRIES];
  logic [LPG_W-1:0] lpg_arr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic             sel;
    logic             acc_q, acc_d;
    logic [LPG_W-1:0] lpg_q, lpg_d;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      acc_d = acc_q;
      lpg_d = lpg_q;
      if (sel) begin
        acc_d = wr_accept;
        lpg_d = wr_lpage;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q <= 1'b0;
        lpg_q <= '0;
      end else if (sel) begin
        acc_q <= acc_d;
        lpg_q <= lpg_d;
      end
    end

    assign acc_arr[g] = acc_q;
    assign lpg_arr[g] = lpg_q;
  end

  assign rd_accept = acc_arr[rd_idx];
  assign rd_lpage  = lpg_arr[rd_idx];
endmodule

// File: rtl/bsr_cycle_decode.sv
module bsr_cycle_decode
  import bsr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe,
  input  logic            write,
  input  logic [AM_W-1:0] am,
  output logic            bcast_start
);
  logic strobe_q;
  logic strobe_d;
  logic user_am;

  assign strobe_d = strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_d;
  end

  assign user_am     = (am[AM_W-1:AM_W-2] == AM_USER_TOP);
  assign bcast_start = strobe && !strobe_q && write && user_am;
endmodule

// File: rtl/bsr_hold_slot.sv
module bsr_hold_slot
  import bsr_pkg::*;
#(
  parameter int LAW = 16,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic [LAW-1:0] in_addr,
  input  logic [DW-1:0]  in_data,
  input  logic           gnt,
  output logic           req,
  output logic [LAW-1:0] out_addr,
  output logic [DW-1:0]  out_data,
  output logic           lost
);
  slot_state_e    state_q, state_d;
  logic [LAW-1:0] addr_q;
  logic [DW-1:0]  data_q;
  logic           lost_q, lost_d;
  logic           granted, room, load, drop;

  assign granted = (state_q == SLOT_FULL) && gnt;
  assign room    = (state_q == SLOT_EMPTY) || granted;
  assign load    = take && room;
  assign drop    = take && !room;

  always_comb begin
    state_d = state_q;
    if (load)         state_d = SLOT_FULL;
    else if (granted) state_d = SLOT_EMPTY;
    lost_d = lost_q | drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SLOT_EMPTY;
      lost_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      lost_q  <= lost_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (load) begin
      addr_q <= in_addr;
      data_q <= in_data;
    end
  end

  assign req      = (state_q == SLOT_FULL);
  assign out_addr = addr_q;
  assign out_data = data_q;
  assign lost     = lost_q;
endmodule

// File: rtl/bcast_snoop_rx.sv
module bcast_snoop_rx
  import bsr_pkg::*;
#(
  parameter int GADDR_W = 16,
  parameter int IDX_W   = 4,
  parameter int LPG_W   = 4,
  parameter int DATA_W  = 16,
  localparam int OFF_W  = GADDR_W - IDX_W,
  localparam int LADDR_W = LPG_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gb_strobe,
  input  logic               gb_write,
  input  logic [AM_W-1:0]    gb_am,
  input  logic [GADDR_W-1:0] gb_addr,
  input  logic [DATA_W-1:0]  gb_data,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic               cfg_accept,
  input  logic [LPG_W-1:0]   cfg_lpage,
  output logic               lw_req,
  output logic [LADDR_W-1:0] lw_addr,
  output logic [DATA_W-1:0]  lw_data,
  input  logic               lw_gnt,
  output logic               overrun
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic             bcast_start;
  logic             page_acc;
  logic [LPG_W-1:0] page_loc;
  logic             hit;
  logic [LADDR_W-1:0] loc_addr;

  bsr_cycle_decode u_decode (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .strobe      (gb_strobe),
    .write       (gb_write),
    .am          (gb_am),
    .bcast_start (bcast_start)
  );

  bsr_map_table #(.IDX_W(IDX_W), .LPG_W(LPG_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .wr_en     (cfg_we),
    .wr_idx    (cfg_idx),
    .wr_accept (cfg_accept),
    .wr_lpage  (cfg_lpage),
    .rd_idx    (gb_addr[GADDR_W-1 -: IDX_W]),
    .rd_accept (page_acc),
    .rd_lpage  (page_loc)
  );

  assign hit      = bcast_start && page_acc;
  assign loc_addr = {page_loc, gb_addr[OFF_W-1:0]};

  bsr_hold_slot #(.LAW(LADDR_W), .DW(DATA_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .take     (hit),
    .in_addr  (loc_addr),
    .in_data  (gb_data),
    .gnt      (lw_gnt),
    .req      (lw_req),
    .out_addr (lw_addr),
    .out_data (lw_data),
    .lost     (overrun)
  );
endmodule

// File: rtl/bcast_snoop_rx_chk.sv
module bcast_snoop_rx_chk #(
  parameter int LAW = 16,
  parameter int DW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           gb_strobe,
  input logic           gb_write,
  input logic [5:0]     gb_am,
  input logic           hit,
  input logic           lw_req,
  input logic [LAW-1:0] lw_addr,
  input logic [DW-1:0]  lw_data,
  input logic           lw_gnt,
  input logic           overrun
);
  assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_req && !lw_gnt) |=> (lw_req && $stable(lw_addr) && $stable(lw_data)));

  assert_req_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_req && lw_gnt && !hit) |=> !lw_req);

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(lw_req && !lw_gnt));

  // a new request needs a strobed write with a user-range modifier (R2, R3)
  assert_req_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lw_req) |-> $past(gb_strobe && gb_write && gb_am[5:4] == 2'b01));

  assert_edge_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !$past(gb_strobe));
endmodule

bind bcast_snoop_rx bcast_snoop_rx_chk #(.LAW(LADDR_W), .DW(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_q),
  .gb_strobe (gb_strobe),
  .gb_write  (gb_write),
  .gb_am     (gb_am),
  .hit       (hit),
  .lw_req    (lw_req),
  .lw_addr   (lw_addr),
  .lw_data   (lw_data),
  .lw_gnt    (lw_gnt),
  .overrun   (overrun)
);

// File: tb/bcast_snoop_rx_bench.sv
module bcast_snoop_rx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gb_strobe = 1'b0, gb_write = 1'b0;
  logic [5:0]  gb_am = '0;
  logic [15:0] gb_addr = '0, gb_data = '0;
  logic        cfg_we = 1'b0, cfg_accept = 1'b0;
  logic [3:0]  cfg_idx = '0, cfg_lpage = '0;
  logic        lw_req, overrun;
  logic [15:0] lw_addr, lw_data;
  logic        lw_gnt = 1'b0;

  always #10 clk = ~clk;

  bcast_snoop_rx u_bcast_snoop_rx (
    .clk(clk), .rst_n(rst_n), .gb_strobe(gb_strobe), .gb_write(gb_write),
    .gb_am(gb_am), .gb_addr(gb_addr), .gb_data(gb_data),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_accept(cfg_accept),
    .cfg_lpage(cfg_lpage), .lw_req(lw_req), .lw_addr(lw_addr),
    .lw_data(lw_data), .lw_gnt(lw_gnt), .overrun(overrun)
  );

  int          checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  logic        mdl_acc [16];
  logic [3:0]  mdl_lp  [16];
  bit          mdl_full = 0, exp_ovr = 0, gnt_auto = 0, grant_once = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(int idx, bit acc, logic [3:0] lp);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx[3:0]; cfg_accept = acc; cfg_lpage = lp;
    @(negedge clk);
    cfg_we = 0;
    mdl_acc[idx] = acc; mdl_lp[idx] = lp;
  endtask

  // driver: one bus cycle, strobe high for 'hold' clock edges
  task automatic bus(logic [5:0] am, bit wr, logic [15:0] a, logic [15:0] d, int hold);
    @(negedge clk);
    gb_strobe = 1; gb_write = wr; gb_am = am; gb_addr = a; gb_data = d;
    #1;
    if (am[5:4] == 2'b01 && wr && mdl_acc[a[15:12]]) begin
      if (!mdl_full) begin
        exp_q.push_back({mdl_lp[a[15:12]], a[11:0], d});
        mdl_full = 1;
      end else exp_ovr = 1;
    end
    repeat (hold) @(negedge clk);
    gb_strobe = 0; gb_write = 0; gb_addr = 16'hDEAD; gb_data = 16'hBEEF;
    @(negedge clk);
  endtask

  // monitor: grants pending requests and compares against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (lw_gnt) lw_gnt = 0;
      else if (lw_req && (gnt_auto || grant_once)) begin
        grant_once = 0;
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R4/R6 unexpected write actual=%h expected=none", {lw_addr, lw_data});
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          if ({lw_addr, lw_data} !== e) begin
            fails++;
            $display("FAIL R5 local write actual=%h expected=%h", {lw_addr, lw_data}, e);
          end
        end
        mdl_full = 0;
        lw_gnt = 1;
      end
    end
  end

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mdl_acc[i] = 0; mdl_lp[i] = 0; end
    settle(3);
    rst_n = 1;
    settle(3);
    check("R1 lw_req after reset", {31'd0, lw_req}, 32'd0);
    check("R1 overrun after reset", {31'd0, overrun}, 32'd0);
    gnt_auto = 1;
    // R1: empty table takes nothing
    bus(6'h10, 1, 16'h3123, 16'h1111, 1);
    settle(3);
    check("R1 no write with cleared table", {31'd0, lw_req}, 32'd0);

    // R10: load table
    cfg(3, 1, 4'hA);
    cfg(5, 1, 4'h2);
    cfg(7, 0, 4'h1);

    // R5 / R2 boundary values inside the window
    bus(6'h10, 1, 16'h3456, 16'hA5A5, 1);
    settle(3);
    bus(6'h1F, 1, 16'h5FFF, 16'h0F0F, 1);
    settle(3);
    // R2 outside window
    bus(6'h0F, 1, 16'h3001, 16'h2222, 1);
    bus(6'h20, 1, 16'h3002, 16'h3333, 1);
    settle(3);
    check("R2 modifier outside window ignored", {31'd0, lw_req}, 32'd0);
    // R3 reads
    bus(6'h15, 0, 16'h3003, 16'h4444, 1);
    settle(3);
    check("R3 read ignored", {31'd0, lw_req}, 32'd0);
    // R4 page with cleared flag
    bus(6'h12, 1, 16'h7004, 16'h5555, 1);
    settle(3);
    check("R4 unaccepted page ignored", {31'd0, lw_req}, 32'd0);
    // R6 long strobe gives one write
    bus(6'h11, 1, 16'h5ABC, 16'h6666, 6);
    settle(3);
    check("R6 one write per strobe", exp_q.size(), 32'd0);
    check("R6 no request left", {31'd0, lw_req}, 32'd0);

    // R9 slot freed and refilled on the same edge
    gnt_auto = 0;
    bus(6'h13, 1, 16'h3010, 16'h7777, 1);
    check("R7 request raised after capture", {31'd0, lw_req}, 32'd1);
    grant_once = 1;
    bus(6'h13, 1, 16'h5020, 16'h8888, 1);
    check("R9 no overrun on grant edge", {31'd0, overrun}, 32'd0);
    check("R9 new request pending", {31'd0, lw_req}, 32'd1);
    check("R9 new address held", {16'd0, lw_addr}, {16'd0, 16'h2020});
    gnt_auto = 1;
    settle(4);
    check("R7 request dropped after grant", {31'd0, lw_req}, 32'd0);

    // R8 overrun
    gnt_auto = 0;
    bus(6'h1A, 1, 16'h3100, 16'h9999, 1);
    bus(6'h1A, 1, 16'h5200, 16'hAAAA, 1);
    settle(3);
    check("R8 overrun set", {31'd0, overrun}, {31'd0, exp_ovr});
    check("R7/R8 pending address kept", {16'd0, lw_addr}, {16'd0, 16'hA100});
    check("R7/R8 pending data kept", {16'd0, lw_data}, {16'd0, 16'h9999});
    gnt_auto = 1;
    settle(4);
    check("R8 dropped write never issued", exp_q.size(), 32'd0);
    check("R8 overrun sticky", {31'd0, overrun}, 32'd1);

    // R10 rewrite entries
    cfg(3, 1, 4'h6);
    bus(6'h1C, 1, 16'h3ABC, 16'hCAFE, 1);
    settle(3);
    cfg(3, 0, 4'h6);
    bus(6'h1C, 1, 16'h3ABD, 16'hF00D, 1);
    settle(3);
    check("R10 disabled entry ignored", {31'd0, lw_req}, 32'd0);
    check("R10 scoreboard drained", exp_q.size(), 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule